// File: doc/BRIEF.md
# Integer ALU with Shifter

This block is the integer execute unit of a 32-bit load/store core. It is purely combinational. The decoder supplies a source register value, a second register value, the 16-bit immediate, a 5-bit constant shift amount, and an operation code. It also supplies three steering bits: one picks the immediate over the second register, one picks zero extension over sign extension of the immediate, and one takes the shift amount from the low bits of the source register instead of the constant.

In the same evaluation the block returns the 32-bit result and an overflow flag. The flag rises only for the trapping add and subtract forms. A separate write-kill output lets the register-file write port drop the destination update when such a trap fires.

Internally a single adder-subtractor serves addition, subtraction and both compares. A logarithmic barrel shifter serves all three shift kinds. A final select routes the result of the chosen operation to the output.

Top module: `int_alu`

## Requirements
- R1: With `alu_op`=0 (trapping add) or 2 (trapping subtract), `result` is the two's-complement sum or difference modulo 2^32 of `rs_val` and the second operand. `ovf` is 1 exactly when the true signed result lies outside the signed 32-bit range.
- R2: With `alu_op`=1 (wrapping add) or 3 (wrapping subtract), `result` is the modulo-2^32 sum or difference and `ovf` is 0 for all operands.
- R3: `wr_kill` equals `ovf` for every input, so a destination write is suppressed whenever the trap fires.
- R4: `alu_op`=4, 5, 6 and 7 give the bitwise AND, OR, XOR and NOR of `rs_val` and the second operand. NOR is the complement of the OR.
- R5: `alu_op`=8 returns 1 when `rs_val` is less than the second operand as signed values and 0 otherwise, with bits 31:1 always 0.
- R6: `alu_op`=9 returns 1 when `rs_val` is less than the second operand as unsigned values and 0 otherwise. When the immediate is used it is sign-extended first and then compared as unsigned.
- R7: `alu_op`=10 shifts `rt_val` left by the shift amount and fills the vacated low bits with zeros.
- R8: `alu_op`=11 shifts `rt_val` right and fills with zeros. `alu_op`=12 shifts it right and replicates bit 31.
- R9: With `sh_var`=0 the shift amount is `shamt`. With `sh_var`=1 it is `rs_val[4:0]`, and `rs_val[31:5]` have no effect on the result.
- R10: With `b_imm`=0 the second operand is `rt_val`. With `b_imm`=1 it is `imm16`, zero-extended when `imm_zext`=1 and sign-extended from bit 15 when `imm_zext`=0.
- R11: `alu_op`=13 places `imm16` in bits 31:16 of `result` and clears bits 15:0.
- R12: Every `alu_op` other than 0 and 2 drives `ovf` to 0. Codes 14 and 15 give `result`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| alu_op | input | 4 | Operation code (see R1 to R12) |
| rs_val | input | 32 | First operand; source of the variable shift amount |
| rt_val | input | 32 | Second register operand; value that shifts act on |
| imm16 | input | 16 | Instruction immediate |
| b_imm | input | 1 | Select immediate as second operand |
| imm_zext | input | 1 | Zero-extend the immediate instead of sign-extending it |
| shamt | input | 5 | Constant shift amount |
| sh_var | input | 1 | Take the shift amount from `rs_val[4:0]` |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed overflow trap on trapping add/subtract |
| wr_kill | output | 1 | Suppress destination register write |

## Verification
The bench builds the block with its default widths: a 32-bit datapath, a 16-bit immediate and hence a five-stage shifter. At these widths the signed range edges 0x7FFFFFFF and 0x80000000 can be hit directly, as can shift distances of 0 and 31. Immediates with bit 15 set expose the difference between the two extension policies, and between the signed and unsigned compares that follow them. A behavioural model using 64-bit integers predicts every output. It is compared against the block for directed corner vectors and for a stream of pseudo-random operations.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOR  = 4'd7,
        OP_SLT  = 4'd8,
        OP_SLTU = 4'd9,
        OP_SLL  = 4'd10,
        OP_SRL  = 4'd11,
        OP_SRA  = 4'd12,
        OP_LUI  = 4'd13
    } alu_op_e;

    typedef enum logic [1:0] {
        SHK_LEFT   = 2'd0,
        SHK_RLOGIC = 2'd1,
        SHK_RARITH = 2'd2
    } shift_kind_e;
endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] rt_val,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  logic              zext,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [EXT_W-1:0] ext_bits;

    always_comb begin
        ext_bits = zext ? '0 : {EXT_W{imm[IMM_W-1]}};
        opnd_b   = use_imm ? {ext_bits, imm} : rt_val;
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              ovf_raw,
    output logic              lt_signed,
    output logic              lt_unsigned
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic              carry;

    always_comb begin
        b_eff          = sub ? ~b : b;
        {carry, sum}   = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
        ovf_raw        = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
        lt_signed      = sum[MSB] ^ ovf_raw;
        lt_unsigned    = sub & ~carry;
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import int_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SH_W-1:0]   amt,
    input  shift_kind_e       kind,
    output logic [DATA_W-1:0] dout
);
    logic              left;
    logic              fill;
    logic [DATA_W-1:0] din_rev;
    logic [DATA_W-1:0] out_rev;
    logic [DATA_W-1:0] stg [SH_W+1];

    always_comb begin
        left = (kind == SHK_LEFT);
        fill = (kind == SHK_RARITH) ? din[DATA_W-1] : 1'b0;
        for (int k = 0; k < DATA_W; k++) begin
            din_rev[k] = din[DATA_W-1-k];
        end
    end

    assign stg[0] = left ? din_rev : din;

    for (genvar i = 0; i < SH_W; i++) begin : g_stage
        localparam int STEP = 1 << i;
        assign stg[i+1] = amt[i] ? {{STEP{fill}}, stg[i][DATA_W-1:STEP]} : stg[i];
    end

    always_comb begin
        for (int k = 0; k < DATA_W; k++) begin
            out_rev[k] = stg[SH_W][DATA_W-1-k];
        end
        dout = left ? out_rev : stg[SH_W];
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [OP_W-1:0]   alu_op,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    input  logic [IMM_W-1:0]  imm16,
    input  logic              b_imm,
    input  logic              imm_zext,
    input  logic [SH_W-1:0]   shamt,
    input  logic              sh_var,
    output logic [DATA_W-1:0] result,
    output logic              ovf,
    output logic              wr_kill
);
    localparam int LOW_W = DATA_W - IMM_W;

    alu_op_e           op;
    logic [DATA_W-1:0] opnd_b;
    logic              do_sub;
    logic              trap_op;
    logic [DATA_W-1:0] sum;
    logic              ovf_raw;
    logic              lt_s;
    logic              lt_u;
    logic [SH_W-1:0]   sh_amt;
    shift_kind_e       sh_kind;
    logic [DATA_W-1:0] sh_out;

    assign op = alu_op_e'(alu_op);

    alu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .rt_val  (rt_val),
        .imm     (imm16),
        .use_imm (b_imm),
        .zext    (imm_zext),
        .opnd_b  (opnd_b)
    );

    always_comb begin
        do_sub  = (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);
        trap_op = (op == OP_ADD) || (op == OP_SUB);
        sh_amt  = sh_var ? rs_val[SH_W-1:0] : shamt;
        unique case (op)
            OP_SRL:  sh_kind = SHK_RLOGIC;
            OP_SRA:  sh_kind = SHK_RARITH;
            default: sh_kind = SHK_LEFT;
        endcase
    end

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a           (rs_val),
        .b           (opnd_b),
        .sub         (do_sub),
        .sum         (sum),
        .ovf_raw     (ovf_raw),
        .lt_signed   (lt_s),
        .lt_unsigned (lt_u)
    );

    alu_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
        .din  (rt_val),
        .amt  (sh_amt),
        .kind (sh_kind),
        .dout (sh_out)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_ADDU,
            OP_SUB, OP_SUBU: result = sum;
            OP_AND:          result = rs_val & opnd_b;
            OP_OR:           result = rs_val | opnd_b;
            OP_XOR:          result = rs_val ^ opnd_b;
            OP_NOR:          result = ~(rs_val | opnd_b);
            OP_SLT:          result = {{(DATA_W-1){1'b0}}, lt_s};
            OP_SLTU:         result = {{(DATA_W-1){1'b0}}, lt_u};
            OP_SLL, OP_SRL,
            OP_SRA:          result = sh_out;
            OP_LUI:          result = {imm16, {LOW_W{1'b0}}};
            default:         result = '0;
        endcase
        ovf     = trap_op & ovf_raw;
        wr_kill = ovf;
    end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int SH_W   = 5
) (
    input logic [3:0]        alu_op,
    input logic [DATA_W-1:0] rs_val,
    input logic [SH_W-1:0]   shamt,
    input logic              sh_var,
    input logic [DATA_W-1:0] result,
    input logic              ovf,
    input logic              wr_kill
);
    localparam int LOW_W = DATA_W - IMM_W;

    logic [SH_W-1:0] amt;

    always_comb begin
        amt = sh_var ? rs_val[SH_W-1:0] : shamt;

        // R12
        ovf_scope_chk: assert (!ovf || alu_op == 4'd0 || alu_op == 4'd2);

        // R1
        ovf_sign_chk: assert (!ovf || (result[DATA_W-1] != rs_val[DATA_W-1]));

        // R3
        kill_match_chk: assert (wr_kill == ovf);

        // R5
        slt_bool_chk: assert (!(alu_op == 4'd8 || alu_op == 4'd9) || result[DATA_W-1:1] == '0);

        // R11
        lui_low_chk: assert (alu_op != 4'd13 || result[LOW_W-1:0] == '0);

        // R8
        srl_fill_chk: assert (!(alu_op == 4'd11 && amt != '0) || !result[DATA_W-1]);
    end
endmodule

bind int_alu int_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SH_W(SH_W)) u_chk (
    .alu_op  (alu_op),
    .rs_val  (rs_val),
    .shamt   (shamt),
    .sh_var  (sh_var),
    .result  (result),
    .ovf     (ovf),
    .wr_kill (wr_kill)
);

// File: tb/tb_int_alu.sv
module tb_int_alu;
    logic        clk = 1'b0;
    logic [3:0]  alu_op = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [15:0] imm16 = '0;
    logic        b_imm = 1'b0;
    logic        imm_zext = 1'b0;
    logic [4:0]  shamt = '0;
    logic        sh_var = 1'b0;
    logic [31:0] result;
    logic        ovf;
    logic        wr_kill;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    int_alu dut (
        .alu_op   (alu_op),
        .rs_val   (rs_val),
        .rt_val   (rt_val),
        .imm16    (imm16),
        .b_imm    (b_imm),
        .imm_zext (imm_zext),
        .shamt    (shamt),
        .sh_var   (sh_var),
        .result   (result),
        .ovf      (ovf),
        .wr_kill  (wr_kill)
    );

    function automatic string op_tag(input logic [3:0] op);
        case (op)
            4'd0, 4'd2:           return "R1";
            4'd1, 4'd3:           return "R2";
            4'd4, 4'd5, 4'd6, 4'd7: return "R4";
            4'd8:                 return "R5";
            4'd9:                 return "R6";
            4'd10:                return "R7";
            4'd11, 4'd12:         return "R8";
            4'd13:                return "R11";
            default:              return "R12";
        endcase
    endfunction

    task automatic model(output logic [31:0] r, output logic o);
        logic [31:0] b;
        int unsigned n;
        longint sa, sb, s;
        b  = b_imm ? (imm_zext ? {16'h0, imm16} : {{16{imm16[15]}}, imm16}) : rt_val;
        n  = sh_var ? int'(rs_val % 32) : int'(shamt);
        sa = longint'($signed(rs_val));
        sb = longint'($signed(b));
        o  = 1'b0;
        r  = '0;
        case (alu_op)
            4'd0, 4'd1: begin
                s = sa + sb; r = s[31:0];
                o = (alu_op == 4'd0) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            4'd2, 4'd3: begin
                s = sa - sb; r = s[31:0];
                o = (alu_op == 4'd2) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            4'd4:  r = rs_val & b;
            4'd5:  r = rs_val | b;
            4'd6:  r = rs_val ^ b;
            4'd7:  r = ~(rs_val | b);
            4'd8:  r = (sa < sb) ? 32'd1 : 32'd0;
            4'd9:  r = (rs_val < b) ? 32'd1 : 32'd0;
            4'd10: r = rt_val << n;
            4'd11: r = rt_val >> n;
            4'd12: r = 32'($signed(rt_val) >>> n);
            4'd13: r = {imm16, 16'h0};
            default: r = '0;
        endcase
    endtask

    task automatic compare(input string tag);
        logic [31:0] er;
        logic eo;
        model(er, eo);
        checks++;
        if (result !== er) begin
            errors++;
            $display("FAIL %s result op=%0d got %h expected %h", tag, alu_op, result, er);
        end
        checks++;
        if (ovf !== eo) begin
            errors++;
            $display("FAIL %s ovf op=%0d got %b expected %b", tag, alu_op, ovf, eo);
        end
        checks++;
        if (wr_kill !== eo) begin
            errors++;
            $display("FAIL R3 wr_kill op=%0d got %b expected %b", alu_op, wr_kill, eo);
        end
    endtask

    task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] t,
                       input logic [15:0] im, input logic bi, input logic zx,
                       input logic [4:0] sa, input logic sv, input string tag);
        @(posedge clk);
        alu_op = op; rs_val = a; rt_val = t; imm16 = im;
        b_imm = bi; imm_zext = zx; shamt = sa; sh_var = sv;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        // idle state: all inputs zero
        @(negedge clk);
        compare("R1 idle");

        run(4'd0, 32'h7FFFFFFF, 32'h1, 16'h0, 0, 0, 0, 0, "R1 add pos ovf");
        run(4'd0, 32'h80000000, 32'hFFFFFFFF, 16'h0, 0, 0, 0, 0, "R1 add neg ovf");
        run(4'd2, 32'h80000000, 32'h1, 16'h0, 0, 0, 0, 0, "R1 sub ovf");
        run(4'd2, 32'h5, 32'h7, 16'h0, 0, 0, 0, 0, "R1 sub no ovf");
        run(4'd0, 32'h7FFFFFFF, 32'h0, 16'h0001, 1, 0, 0, 0, "R1 addi ovf");
        run(4'd1, 32'h7FFFFFFF, 32'h1, 16'h0, 0, 0, 0, 0, "R2 addu wrap");
        run(4'd3, 32'h80000000, 32'h1, 16'h0, 0, 0, 0, 0, "R2 subu wrap");
        run(4'd7, 32'hF0F00000, 32'h0000F0F0, 16'h0, 0, 0, 0, 0, "R4 nor");
        run(4'd5, 32'h12340000, 32'h0, 16'h8001, 1, 1, 0, 0, "R10 ori zext");
        run(4'd4, 32'hFFFFFFFF, 32'h0, 16'h8001, 1, 1, 0, 0, "R10 andi zext");
        run(4'd1, 32'h10, 32'h0, 16'hFFFF, 1, 0, 0, 0, "R10 addiu sext");
        run(4'd8, 32'hFFFFFFFF, 32'h1, 16'h0, 0, 0, 0, 0, "R5 slt neg<pos");
        run(4'd8, 32'h80000000, 32'h7FFFFFFF, 16'h0, 0, 0, 0, 0, "R5 slt extremes");
        run(4'd9, 32'hFFFFFFFF, 32'h1, 16'h0, 0, 0, 0, 0, "R6 sltu big");
        run(4'd9, 32'h00001000, 32'h0, 16'hFFFF, 1, 0, 0, 0, "R6 sltiu sext");
        run(4'd8, 32'h00000005, 32'h0, 16'hFFFF, 1, 0, 0, 0, "R5 slti sext");
        run(4'd10, 32'h0, 32'h80000001, 16'h0, 0, 0, 5'd31, 0, "R7 sll 31");
        run(4'd10, 32'h0, 32'hA5A5A5A5, 16'h0, 0, 0, 5'd0, 0, "R7 sll 0");
        run(4'd11, 32'h0, 32'h80000000, 16'h0, 0, 0, 5'd31, 0, "R8 srl 31");
        run(4'd12, 32'h0, 32'h80000000, 16'h0, 0, 0, 5'd31, 0, "R8 sra 31");
        run(4'd12, 32'h0, 32'h40000000, 16'h0, 0, 0, 5'd4, 0, "R8 sra pos");
        run(4'd12, 32'hFFFFFFE4, 32'hF0000000, 16'h0, 0, 0, 5'd1, 1, "R9 srav hi bits ignored");
        run(4'd10, 32'h00000123, 32'h1, 16'h0, 0, 0, 5'd7, 1, "R9 sllv low bits");
        run(4'd13, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hBEEF, 0, 0, 0, 0, "R11 lui");
        run(4'd4, 32'h7FFFFFFF, 32'h7FFFFFFF, 16'h0, 0, 0, 0, 0, "R12 and no ovf");
        run(4'd14, 32'h7FFFFFFF, 32'h1, 16'h0, 0, 0, 0, 0, "R12 unused code");

        for (int i = 0; i < 600; i++) begin
            logic [3:0] op;
            op = 4'($urandom % 16);
            run(op, $urandom, $urandom, 16'($urandom), 1'($urandom), 1'($urandom),
                5'($urandom), 1'($urandom), op_tag(op));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule